// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block sits beside a processor core and watches three things every cycle: the program counter, the address of the current bus cycle and the data of that cycle. Software loads reference values and masks through a small register port. A trigger fires when the conditions it has enabled all match. A trigger can be a single event, or a two-step sequence in which a first event arms the unit and a later second event fires it. A fired trigger becomes either a halt request or a debug interrupt request. Each request is a one-cycle pulse.

There are four program-counter references that share one mask. There is one address reference with its own mask, and one data reference with its own mask. A mask bit of 1 excludes that bit from the compare. A control register chooses the conditions for each level, the sequencing mode, the response and an optional read/write qualifier on bus cycles. A status register records which kind of trigger fired and whether the sequence is armed. The block also drives a halted indication taken from the core's four processor-status bits.

The control and status pins are plain level signals. No data streams through the block, so no port has a handshake or back-pressure.

Top module: `bkpt_trigger`

## Requirements
- R1: After reset every register reads zero, and halt_req and dbg_irq are low.
- R2: Register map by cfg_addr: 0..3 PC references, 4 PC mask, 5 address reference, 6 address mask, 7 data reference, 8 data mask, 9 control, 10 status. A write takes effect at the clock edge. Reads are combinational. Control reads back only bits [9:0]. Addresses 11..15 read zero and cannot be written.
- R3: A compare matches when ((value XOR reference) AND NOT mask) is zero, so a mask bit of 1 makes that bit irrelevant.
- R4: The PC condition is true when pc_valid is high and pc_value matches any of the four PC references under the shared PC mask.
- R5: The address and data conditions need bus_valid high. When control bit 8 is set, they also need bus_rd to equal control bit 9.
- R6: Control bits [2:0] enable the level-1 conditions and bits [5:3] enable the level-2 conditions. Within each group, bit 0 is PC, bit 1 is address and bit 2 is data. A level matches only when at least one of its conditions is enabled and every enabled condition is true. A level with no enables never matches.
- R7: When control bit 6 is 0 (single level), a level-1 match in cycle n produces a response pulse in cycle n+1 and sets status bit 0.
- R8: When control bit 6 is 1 (two level), a level-1 match sets the armed flag (status bit 2) without firing. A level-2 match in a later cycle while armed fires, sets status bit 1 and clears armed. A level-2 match while not armed, or in the same cycle that arms, does not fire.
- R9: Control bit 7 selects the response: 0 pulses halt_req and 1 pulses dbg_irq. The two are never high together.
- R10: Status bits 0 and 1 stay set until a write to the status register with a 1 in that bit position; zero bits in the write leave them unchanged. Any write to the control register clears the armed flag.
- R11: cpu_halted is high exactly when all four cpu_pstat bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| pc_valid | input | 1 | pc_value is meaningful this cycle |
| pc_value | input | 32 | Program counter |
| bus_valid | input | 1 | A bus cycle is present this cycle |
| bus_rd | input | 1 | 1 for a read bus cycle, 0 for a write |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| cpu_pstat | input | 4 | Processor status bits |
| halt_req | output | 1 | One-cycle halt request pulse |
| dbg_irq | output | 1 | One-cycle debug interrupt request pulse |
| cpu_halted | output | 1 | High when processor status is all ones |

## Verification
The hardest cases to reach are in the two-level sequence. One is a level-2 match that arrives in the same cycle as the arming event. The other is an armed state that a control write clears before level 2 ever matches. Neither case leaves a mark on the outputs except through the absence of a pulse. The bench therefore drives explicit cycle-by-cycle PC and data patterns: level 2 alone, level 1 repeated, both at once, and arming followed by a control rewrite. After each step it reads the armed bit back through the status register, so the hidden flag becomes visible at the ports. The compare logic is covered by sweeps over reference, mask, valid and direction combinations, with the expected match worked out arithmetically.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned COND_PC   = 0;
  localparam int unsigned COND_ADDR = 1;
  localparam int unsigned COND_DATA = 2;
  localparam int unsigned NCOND     = 3;

  typedef enum logic { RESP_HALT = 1'b0, RESP_IRQ = 1'b1 } resp_e;

  typedef struct packed {
    logic             dir_rd;
    logic             dir_chk;
    resp_e            resp;
    logic             two_level;
    logic [NCOND-1:0] l2_en;
    logic [NCOND-1:0] l1_en;
  } ctl_t;

  localparam int unsigned CTLW = $bits(ctl_t);
endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import bkpt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NPC = 4,
  parameter int RAW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RAW-1:0]          addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [NCOND-1:0]        status,
  output logic [NPC-1:0][DW-1:0]  pc_ref,
  output logic [DW-1:0]           pc_mask,
  output logic [DW-1:0]           addr_ref,
  output logic [DW-1:0]           addr_mask,
  output logic [DW-1:0]           data_ref,
  output logic [DW-1:0]           data_mask,
  output ctl_t                    ctl,
  output logic                    ctl_wr,
  output logic                    stat_clr_en,
  output logic [1:0]              stat_clr
);
  localparam logic [RAW-1:0] IDX_PCM = RAW'(NPC);
  localparam logic [RAW-1:0] IDX_AR  = RAW'(NPC + 1);
  localparam logic [RAW-1:0] IDX_AM  = RAW'(NPC + 2);
  localparam logic [RAW-1:0] IDX_DR  = RAW'(NPC + 3);
  localparam logic [RAW-1:0] IDX_DM  = RAW'(NPC + 4);
  localparam logic [RAW-1:0] IDX_CTL = RAW'(NPC + 5);
  localparam logic [RAW-1:0] IDX_ST  = RAW'(NPC + 6);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_ref    <= '0;
      pc_mask   <= '0;
      addr_ref  <= '0;
      addr_mask <= '0;
      data_ref  <= '0;
      data_mask <= '0;
      ctl       <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NPC; k++) begin
        if (addr == RAW'(k)) pc_ref[k] <= wdata;
      end
      if (addr == IDX_PCM) pc_mask   <= wdata;
      if (addr == IDX_AR)  addr_ref  <= wdata;
      if (addr == IDX_AM)  addr_mask <= wdata;
      if (addr == IDX_DR)  data_ref  <= wdata;
      if (addr == IDX_DM)  data_mask <= wdata;
      if (addr == IDX_CTL) ctl       <= ctl_t'(wdata[CTLW-1:0]);
    end
  end

  assign ctl_wr      = wr_en && (addr == IDX_CTL);
  assign stat_clr_en = wr_en && (addr == IDX_ST);
  assign stat_clr    = wdata[1:0];

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NPC; k++) begin
      if (addr == RAW'(k)) rdata = pc_ref[k];
    end
    if (addr == IDX_PCM) rdata = pc_mask;
    if (addr == IDX_AR)  rdata = addr_ref;
    if (addr == IDX_AM)  rdata = addr_mask;
    if (addr == IDX_DR)  rdata = data_ref;
    if (addr == IDX_DM)  rdata = data_mask;
    if (addr == IDX_CTL) rdata = DW'(ctl);
    if (addr == IDX_ST)  rdata = DW'(status);
  end

  // R2: a mask write lands exactly one edge later
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == IDX_PCM) |-> pc_mask == $past(wdata));
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] refv,
  input  logic [DW-1:0] msk,
  output logic          hit
);
  assign hit = ((val ^ refv) & ~msk) == '0;
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NPC = 4
) (
  input  logic                   pc_valid,
  input  logic [DW-1:0]          pc_value,
  input  logic [NPC-1:0][DW-1:0] pc_ref,
  input  logic [DW-1:0]          pc_mask,
  input  logic                   bus_valid,
  input  logic                   bus_rd,
  input  logic [DW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_data,
  input  logic [DW-1:0]          addr_ref,
  input  logic [DW-1:0]          addr_mask,
  input  logic [DW-1:0]          data_ref,
  input  logic [DW-1:0]          data_mask,
  input  logic                   dir_chk,
  input  logic                   dir_rd,
  output logic [NCOND-1:0]       cond
);
  logic [NPC-1:0] pc_hits;
  logic           a_hit, d_hit, bus_ok;

  for (genvar g = 0; g < NPC; g++) begin : g_pc
    bkpt_cmp #(.DW(DW)) u_cmp (
      .val (pc_value),
      .refv(pc_ref[g]),
      .msk (pc_mask),
      .hit (pc_hits[g])
    );
  end

  bkpt_cmp #(.DW(DW)) u_addr_cmp (
    .val(bus_addr), .refv(addr_ref), .msk(addr_mask), .hit(a_hit)
  );
  bkpt_cmp #(.DW(DW)) u_data_cmp (
    .val(bus_data), .refv(data_ref), .msk(data_mask), .hit(d_hit)
  );

  assign bus_ok          = bus_valid && (!dir_chk || (bus_rd == dir_rd));
  assign cond[COND_PC]   = pc_valid && (|pc_hits);
  assign cond[COND_ADDR] = bus_ok && a_hit;
  assign cond[COND_DATA] = bus_ok && d_hit;
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] cond,
  input  logic [NCOND-1:0] l1_en,
  input  logic [NCOND-1:0] l2_en,
  input  logic             two_level,
  input  resp_e            resp,
  input  logic             ctl_wr,
  input  logic             stat_clr_en,
  input  logic [1:0]       stat_clr,
  output logic             halt_req,
  output logic             dbg_irq,
  output logic [NCOND-1:0] status
);
  logic l1_hit, l2_hit, fire1, fire2, arm_set;
  logic armed_q, hit1_q, hit2_q;

  assign l1_hit  = (|l1_en) && ((cond & l1_en) == l1_en);
  assign l2_hit  = (|l2_en) && ((cond & l2_en) == l2_en);
  assign fire1   = !two_level && l1_hit;
  assign fire2   = two_level && armed_q && l2_hit;
  assign arm_set = two_level && !armed_q && l1_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      hit1_q   <= 1'b0;
      hit2_q   <= 1'b0;
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
    end else begin
      if (ctl_wr || fire2) armed_q <= 1'b0;
      else if (arm_set)    armed_q <= 1'b1;
      hit1_q   <= (hit1_q & ~(stat_clr_en & stat_clr[0])) | fire1;
      hit2_q   <= (hit2_q & ~(stat_clr_en & stat_clr[1])) | fire2;
      halt_req <= (fire1 || fire2) && (resp == RESP_HALT);
      dbg_irq  <= (fire1 || fire2) && (resp == RESP_IRQ);
    end
  end

  assign status = {armed_q, hit2_q, hit1_q};

  assert_one_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq));
  assert_needs_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) && $past(two_level) |-> $past(armed_q));
  assert_fire_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) && $past(two_level) |-> !armed_q);
  assert_sticky_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit1_q) && !$past(stat_clr_en && stat_clr[0]) |-> hit1_q);
  assert_ctl_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr) |-> !armed_q);
endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger
  import bkpt_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NPC = 4,
  parameter int RAW = 4,
  parameter int PSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           pc_valid,
  input  logic [DW-1:0]  pc_value,
  input  logic           bus_valid,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_data,
  input  logic [PSW-1:0] cpu_pstat,
  output logic           halt_req,
  output logic           dbg_irq,
  output logic           cpu_halted
);
  logic [NPC-1:0][DW-1:0] pc_ref;
  logic [DW-1:0]          pc_mask, addr_ref, addr_mask, data_ref, data_mask;
  ctl_t                   ctl;
  logic                   ctl_wr, stat_clr_en;
  logic [1:0]             stat_clr;
  logic [NCOND-1:0]       status, cond;

  bkpt_regfile #(.DW(DW), .NPC(NPC), .RAW(RAW)) u_regs (
    .clk, .rst_n,
    .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .status, .pc_ref, .pc_mask, .addr_ref, .addr_mask, .data_ref, .data_mask,
    .ctl, .ctl_wr, .stat_clr_en, .stat_clr
  );

  bkpt_match #(.DW(DW), .NPC(NPC)) u_match (
    .pc_valid, .pc_value, .pc_ref, .pc_mask,
    .bus_valid, .bus_rd, .bus_addr, .bus_data,
    .addr_ref, .addr_mask, .data_ref, .data_mask,
    .dir_chk(ctl.dir_chk), .dir_rd(ctl.dir_rd), .cond
  );

  bkpt_seq u_seq (
    .clk, .rst_n, .cond,
    .l1_en(ctl.l1_en), .l2_en(ctl.l2_en), .two_level(ctl.two_level),
    .resp(ctl.resp), .ctl_wr, .stat_clr_en, .stat_clr,
    .halt_req, .dbg_irq, .status
  );

  assign cpu_halted = &cpu_pstat;
endmodule

// File: tb/bkpt_trigger_tb_top.sv
module bkpt_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pc_valid = 1'b0;
  logic [31:0] pc_value = '0;
  logic        bus_valid = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic [3:0]  cpu_pstat = '0;
  logic        halt_req, dbg_irq, cpu_halted;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] pcr [4] = '{32'h0000_0100, 32'h0000_2000, 32'h0000_03A5, 32'hFFFF_0000};
  logic [31:0] pcm [3] = '{32'h0, 32'h0000_000F, 32'h0000_0F0F};

  always #4 clk = ~clk;

  bkpt_trigger dut_i (
    .clk, .rst_n, .cfg_wr_en, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .pc_valid, .pc_value, .bus_valid, .bus_rd, .bus_addr, .bus_data,
    .cpu_pstat, .halt_req, .dbg_irq, .cpu_halted
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mhit(input logic [31:0] v, input logic [31:0] r, input logic [31:0] m);
    return ((v ^ r) & ~m) == 32'h0;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    pc_valid = 1'b0; bus_valid = 1'b0;
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic drv2(input logic pcm_on, input logic dm_on);
    pc_valid = 1'b1;
    pc_value = pcm_on ? 32'h0000_0100 : 32'h0000_5555;
    bus_valid = 1'b1; bus_rd = 1'b0; bus_addr = '0;
    bus_data = dm_on ? 32'hCAFE_0001 : 32'h1234_0000;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state
    chk("R1", {30'b0, halt_req, dbg_irq}, 32'h0);
    for (int a = 0; a <= 10; a++) rd_chk("R1", 4'(a), 32'h0);

    // R2: readback of every register, unused addresses
    for (int a = 0; a <= 8; a++) wr(4'(a), 32'h1111_1111 * (a + 1) + 32'h5);
    for (int a = 0; a <= 8; a++) rd_chk("R2", 4'(a), 32'h1111_1111 * (a + 1) + 32'h5);
    wr(4'd9, 32'hFFFF_FFFF);
    rd_chk("R2", 4'd9, 32'h0000_03FF);
    for (int a = 11; a <= 15; a++) begin
      wr(4'(a), 32'hDEAD_BEEF);
      rd_chk("R2", 4'(a), 32'h0);
    end

    // R3/R4/R7: PC compare sweep, single level, halt response
    for (int k = 0; k < 4; k++) wr(4'(k), pcr[k]);
    wr(4'd9, 32'h001);
    for (int mi = 0; mi < 3; mi++) begin
      wr(4'd4, pcm[mi]);
      for (int i = 0; i < 64; i++) begin
        logic e;
        pc_value = pcr[i & 3] ^ (32'(i >> 2) * 32'h11);
        pc_valid = (i % 7) != 3;
        e = 1'b0;
        for (int k = 0; k < 4; k++) e |= mhit(pc_value, pcr[k], pcm[mi]);
        e &= pc_valid;
        cyc();
        chk(mi == 0 ? "R4" : "R3", {30'b0, halt_req, dbg_irq}, {30'b0, e, 1'b0});
      end
    end
    pc_valid = 1'b0;
    rd_chk("R7", 4'd10, 32'h1);

    // R5: address compare with valid and direction qualifiers
    wr(4'd5, 32'h40); wr(4'd6, 32'h3);
    for (int dm = 0; dm < 3; dm++) begin
      logic chkd, rdv;
      chkd = dm != 0; rdv = dm == 1;
      wr(4'd9, {22'b0, rdv, chkd, 8'h02});
      for (int a = 0; a < 32; a++) begin
        for (int v = 0; v < 2; v++) begin
          for (int r = 0; r < 2; r++) begin
            logic e;
            bus_addr = 32'h30 + 32'(a); bus_data = '0;
            bus_valid = v[0]; bus_rd = r[0];
            e = v[0] && mhit(bus_addr, 32'h40, 32'h3) && (!chkd || (r[0] == rdv));
            cyc();
            chk("R5", {30'b0, halt_req, dbg_irq}, {30'b0, e, 1'b0});
          end
        end
      end
    end

    // R6/R9: address AND data, interrupt response
    wr(4'd7, 32'hCAFE_0000); wr(4'd8, 32'h0000_FFFF);
    wr(4'd9, 32'h086);
    for (int i = 0; i < 16; i++) begin
      logic e;
      bus_valid = 1'b1; bus_rd = i[2];
      bus_addr = i[0] ? 32'h48 : 32'h41;
      bus_data = i[1] ? 32'hCAFF_1234 : (32'hCAFE_0000 | 32'(i));
      e = mhit(bus_addr, 32'h40, 32'h3) && mhit(bus_data, 32'hCAFE_0000, 32'hFFFF);
      cyc();
      chk("R9", {30'b0, halt_req, dbg_irq}, {30'b0, 1'b0, e});
    end
    // R6: nothing enabled never matches
    wr(4'd9, 32'h0);
    pc_valid = 1'b1; pc_value = pcr[0];
    bus_valid = 1'b1; bus_addr = 32'h40; bus_data = 32'hCAFE_0000;
    cyc();
    chk("R6", {30'b0, halt_req, dbg_irq}, 32'h0);

    // R8: two-level sequence, level 1 = PC, level 2 = data
    wr(4'd9, 32'h061);
    wr(4'd10, 32'h3);
    rd_chk("R10", 4'd10, 32'h0);
    drv2(1'b0, 1'b1);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h0);
    rd_chk("R8", 4'd10, 32'h0);
    drv2(1'b1, 1'b0);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h0);
    rd_chk("R8", 4'd10, 32'h4);
    drv2(1'b1, 1'b0);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h0);
    drv2(1'b0, 1'b1);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h2);
    rd_chk("R8", 4'd10, 32'h2);
    drv2(1'b0, 1'b0);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h0);
    drv2(1'b1, 1'b1);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h0);
    rd_chk("R8", 4'd10, 32'h6);
    drv2(1'b0, 1'b1);
    chk("R8", {30'b0, halt_req, dbg_irq}, 32'h2);
    // R10: control write disarms
    drv2(1'b1, 1'b0);
    rd_chk("R10", 4'd10, 32'h6);
    wr(4'd9, 32'h061);
    rd_chk("R10", 4'd10, 32'h2);
    drv2(1'b0, 1'b1);
    chk("R10", {30'b0, halt_req, dbg_irq}, 32'h0);
    // R10: sticky status clear
    wr(4'd10, 32'h0);
    rd_chk("R10", 4'd10, 32'h2);
    wr(4'd10, 32'h2);
    rd_chk("R10", 4'd10, 32'h0);

    // R11: halted indication
    for (int p = 0; p < 16; p++) begin
      cpu_pstat = 4'(p);
      #1;
      chk("R11", {31'b0, cpu_halted}, {31'b0, p == 15});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule